// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the software-visible face of a UART. It decodes word-aligned accesses from a simple synchronous bus inside a 4 KiB window, holds the configuration words (divisors, line setup, control, FIFO level select, low-power divisor, DMA control), and returns eight fixed identification bytes from the top of the window. Serial timing, baud generation and DMA transfers sit elsewhere.

Writes to the data word leave at once on a byte-wide transmit strobe, and the transmitter is treated as always empty. Reads of the data word pop a separate receive FIFO, whose head entry and fill count come in on dedicated pins. Transmit and receive events set bits in a raw interrupt status word. Software masks these bits, reads raw or masked views and clears them with write-one-to-clear. A single level interrupt output is the OR of the masked bits.

Top module: `uart_reg_front`

## Requirements
- R1: After reset the control word reads 0x300, the FIFO level select reads 0x12, the mask and raw status read 0, the flag word reads 0x90 while the receive count is 0, and irq, err and tx_valid are low.
- R2: Read data and err are valid in the cycle after the select cycle. The configuration words read back what was written, truncated to their widths: both 8-bit words (offsets 0x20 and 0x2C), the 16-bit words (0x24 and 0x30), the 6-bit words (0x28 and 0x34), the 11-bit mask (0x38) and the 3-bit DMA word (0x48).
- R3: A write to offset 0x00 raises tx_valid for exactly one cycle after the select cycle, with tx_byte equal to wdata[7:0]. It also sets raw status bit 5 (transmit).
- R4: A one-cycle rx_push sets raw status bit 4 (receive). A data read taken while rx_count is 1 clears that bit. When rx_push falls in the same cycle as such a read, the bit stays set.
- R5: A write to offset 0x44 clears exactly those raw status bits that are written as 1 and leaves the others unchanged.
- R6: Offset 0x40 reads raw status AND mask (offset 0x3C reads raw status). irq is high in the cycle after any state change exactly when that AND is nonzero.
- R7: The flag word at 0x18 reads bit 7 = 1 (transmit empty), bit 6 = (rx_count equals the receive depth), bit 5 = 0 (transmit full), bit 4 = (rx_count is 0), and all other bits 0. Writes to it have no effect.
- R8: A read of offset 0x00 returns rx_data zero-extended. rx_pop is high during that select cycle only when rx_count is nonzero.
- R9: Reads from 0xFE0 to 0xFFC return identification byte number (addr-0xFE0)>>2 from the list 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: An access to an undecoded offset (for example 0x04, 0x100, or any write into the identification window) reads 0 and pulses err for one cycle after the select cycle. Decoded accesses leave err low.
- R11: A write to offset 0x48 with wdata[1:0] nonzero still stores the value but pulses err. With wdata[1:0] equal to 0, no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Access select, one access per cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte offset in the window; bits 1:0 ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after select |
| err | output | 1 | One-cycle access error pulse |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit strobe |
| tx_byte | output | 8 | Transmitted byte |
| rx_data | input | RX_W | Head entry of the receive FIFO |
| rx_count | input | CNT_W | Entries held in the receive FIFO |
| rx_push | input | 1 | Pulse: the receive FIFO accepted an entry |
| rx_pop | output | 1 | Pop request to the receive FIFO |

## Verification
The hardest case to reach is a receive push that lands in the same cycle as the read that drains the last FIFO entry, where the set must win over the clear. The bench drives rx_push inside the data-read select cycle while holding rx_count at 1, then reads raw status. It also holds rx_count at the full depth and at zero to reach both flag extremes and the no-pop case, which a real FIFO would reach only after long traffic.

// File: rtl/uart_front_pkg.sv
package uart_front_pkg;
    typedef enum logic [3:0] {
        SLOT_DATA, SLOT_FLAGS, SLOT_LPWR, SLOT_IDIV, SLOT_FDIV, SLOT_LINE,
        SLOT_CTRL, SLOT_LEVEL, SLOT_MASK, SLOT_RAW, SLOT_MASKED, SLOT_CLEAR,
        SLOT_DMA, SLOT_IDENT, SLOT_NONE
    } slot_e;

    localparam int IRQ_W   = 11;
    localparam int TX_BIT  = 5;
    localparam int RX_BIT  = 4;
    localparam int ID_N    = 8;

    localparam logic [15:0] CTRL_RST  = 16'h0300;
    localparam logic [5:0]  LEVEL_RST = 6'h12;

    function automatic logic [7:0] ident_byte(input int idx);
        case (idx)
            0: return 8'h11;
            1: return 8'h10;
            2: return 8'h14;
            3: return 8'h00;
            4: return 8'h0D;
            5: return 8'hF0;
            6: return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/uart_addr_dec.sv
module uart_addr_dec
    import uart_front_pkg::*;
(
    input  logic [9:0] word_addr,
    output slot_e      slot,
    output logic [2:0] id_idx
);
    always_comb begin
        id_idx = word_addr[2:0];
        if (word_addr[9:3] == 7'h7F) begin
            slot = SLOT_IDENT;
        end else begin
            case (word_addr)
                10'h000: slot = SLOT_DATA;
                10'h006: slot = SLOT_FLAGS;
                10'h008: slot = SLOT_LPWR;
                10'h009: slot = SLOT_IDIV;
                10'h00A: slot = SLOT_FDIV;
                10'h00B: slot = SLOT_LINE;
                10'h00C: slot = SLOT_CTRL;
                10'h00D: slot = SLOT_LEVEL;
                10'h00E: slot = SLOT_MASK;
                10'h00F: slot = SLOT_RAW;
                10'h010: slot = SLOT_MASKED;
                10'h011: slot = SLOT_CLEAR;
                10'h012: slot = SLOT_DMA;
                default: slot = SLOT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/uart_id_rom.sv
module uart_id_rom
    import uart_front_pkg::*;
(
    input  logic [2:0] idx,
    output logic [7:0] id_val
);
    logic [7:0] table_w [ID_N];

    for (genvar g = 0; g < ID_N; g++) begin : g_id
        assign table_w[g] = ident_byte(g);
    end

    assign id_val = table_w[idx];
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_front_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic [IRQ_W-1:0] mask_wdata,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] clr_bits,
    input  logic             tx_set,
    input  logic             rx_set,
    input  logic             rx_clr,
    output logic [IRQ_W-1:0] ris,
    output logic [IRQ_W-1:0] mask,
    output logic             irq
);
    typedef struct packed {
        logic [IRQ_W-1:0] ris;
        logic [IRQ_W-1:0] mask;
        logic             irq;
    } irq_state_t;

    irq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (mask_we) s_d.mask = mask_wdata;
        if (clr_we)  s_d.ris  = s_d.ris & ~clr_bits;
        if (rx_clr)  s_d.ris[RX_BIT] = 1'b0;
        if (rx_set)  s_d.ris[RX_BIT] = 1'b1;
        if (tx_set)  s_d.ris[TX_BIT] = 1'b1;
        s_d.irq = |(s_d.ris & s_d.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ris  = s_q.ris;
    assign mask = s_q.mask;
    assign irq  = s_q.irq;

    a_r3_tx_raw_set: assert property (@(posedge clk) disable iff (!rst_n)
        tx_set |=> ris[TX_BIT]);
    a_r4_rx_raw_set: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set |=> ris[RX_BIT]);
    a_r5_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_bits[TX_BIT] && !tx_set) |=> !ris[TX_BIT]);
    a_r5_w1c_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !clr_bits[TX_BIT]) |=> (ris[TX_BIT] == $past(ris[TX_BIT])));
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
    import uart_front_pkg::*;
#(
    parameter int RX_DEPTH = 16,
    parameter int RX_W     = 12,
    localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [11:0]       addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              err,
    output logic              irq,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic [RX_W-1:0]   rx_data,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              rx_push,
    output logic              rx_pop
);
    typedef struct packed {
        logic [7:0]  lpwr;
        logic [15:0] idiv;
        logic [5:0]  fdiv;
        logic [7:0]  line;
        logic [15:0] ctrl;
        logic [5:0]  level;
        logic [2:0]  dma;
        logic [31:0] rdata;
        logic        err;
        logic        tx_valid;
        logic [7:0]  tx_byte;
    } front_state_t;

    front_state_t s_d, s_q;

    slot_e            slot;
    logic [2:0]       id_idx;
    logic [7:0]       id_val;
    logic [IRQ_W-1:0] ris, mask;
    logic             do_rd, do_wr, rx_clr;
    logic [7:0]       flags_w;
    logic             unused_bits;

    assign unused_bits = ^{wdata[31:16], addr[1:0]};

    uart_addr_dec u_dec (.word_addr(addr[11:2]), .slot(slot), .id_idx(id_idx));
    uart_id_rom   u_id  (.idx(id_idx), .id_val(id_val));

    assign do_rd  = sel && !wr;
    assign do_wr  = sel && wr;
    assign rx_pop = do_rd && (slot == SLOT_DATA) && (rx_count != '0);
    assign rx_clr = do_rd && (slot == SLOT_DATA) && (rx_count == CNT_W'(1));
    assign flags_w = {1'b1, rx_count == CNT_W'(RX_DEPTH), 1'b0, rx_count == '0, 4'b0};

    uart_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n),
        .mask_we(do_wr && slot == SLOT_MASK), .mask_wdata(wdata[IRQ_W-1:0]),
        .clr_we(do_wr && slot == SLOT_CLEAR), .clr_bits(wdata[IRQ_W-1:0]),
        .tx_set(do_wr && slot == SLOT_DATA), .rx_set(rx_push), .rx_clr(rx_clr),
        .ris(ris), .mask(mask), .irq(irq)
    );

    always_comb begin
        s_d          = s_q;
        s_d.rdata    = '0;
        s_d.err      = 1'b0;
        s_d.tx_valid = 1'b0;
        if (sel) begin
            unique case (slot)
                SLOT_DATA:   if (wr) begin
                                 s_d.tx_valid = 1'b1;
                                 s_d.tx_byte  = wdata[7:0];
                             end else s_d.rdata = 32'(rx_data);
                SLOT_FLAGS:  if (!wr) s_d.rdata = 32'(flags_w);
                SLOT_LPWR:   if (wr) s_d.lpwr = wdata[7:0];   else s_d.rdata = 32'(s_q.lpwr);
                SLOT_IDIV:   if (wr) s_d.idiv = wdata[15:0];  else s_d.rdata = 32'(s_q.idiv);
                SLOT_FDIV:   if (wr) s_d.fdiv = wdata[5:0];   else s_d.rdata = 32'(s_q.fdiv);
                SLOT_LINE:   if (wr) s_d.line = wdata[7:0];   else s_d.rdata = 32'(s_q.line);
                SLOT_CTRL:   if (wr) s_d.ctrl = wdata[15:0];  else s_d.rdata = 32'(s_q.ctrl);
                SLOT_LEVEL:  if (wr) s_d.level = wdata[5:0];  else s_d.rdata = 32'(s_q.level);
                SLOT_MASK:   if (!wr) s_d.rdata = 32'(mask);
                SLOT_RAW:    if (!wr) s_d.rdata = 32'(ris);
                SLOT_MASKED: if (!wr) s_d.rdata = 32'(ris & mask);
                SLOT_CLEAR:  ;
                SLOT_DMA:    if (wr) begin
                                 s_d.dma = wdata[2:0];
                                 s_d.err = |wdata[1:0];
                             end else s_d.rdata = 32'(s_q.dma);
                SLOT_IDENT:  if (wr) s_d.err = 1'b1; else s_d.rdata = 32'(id_val);
                default:     s_d.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.ctrl  <= CTRL_RST;
            s_q.level <= LEVEL_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata    = s_q.rdata;
    assign err      = s_q.err;
    assign tx_valid = s_q.tx_valid;
    assign tx_byte  = s_q.tx_byte;

    a_r3_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && slot == SLOT_DATA) |=> (tx_valid && tx_byte == $past(wdata[7:0])));
    a_r3_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_wr && slot == SLOT_DATA) |=> !tx_valid);
    a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> !rx_pop);
    a_r10_undecoded_err: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && slot == SLOT_NONE) |=> (err && rdata == '0));
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !err);
endmodule

// File: tb/uart_reg_front_test.sv
module uart_reg_front_test;
    localparam int DEPTH = 16;
    localparam int RW    = 12;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic err, irq, tx_valid, rx_pop;
    logic [7:0] tx_byte;
    logic [RW-1:0] rx_data = '0;
    logic [CW-1:0] rx_count = '0;
    logic rx_push = 1'b0;

    int checks = 0;
    int fails = 0;

    logic [31:0] got_rd;
    logic got_err, got_tx, pop_seen, push_with;
    logic [7:0] got_txb;

    always #2 clk = ~clk;

    uart_reg_front #(.RX_DEPTH(DEPTH), .RX_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
        .rdata(rdata), .err(err), .irq(irq), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .rx_data(rx_data), .rx_count(rx_count), .rx_push(rx_push), .rx_pop(rx_pop)
    );

    typedef struct packed {
        logic        w;
        logic [11:0] a;
        logic [31:0] d;
        logic [31:0] exp;
        logic        exp_err;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 12'h030, 32'h0, 32'h300, 1'b0},        // R1 control reset
        '{1'b0, 12'h034, 32'h0, 32'h12, 1'b0},         // R1 level reset
        '{1'b0, 12'h018, 32'h0, 32'h90, 1'b0},         // R1 flags reset
        '{1'b0, 12'h038, 32'h0, 32'h0, 1'b0},          // R1 mask reset
        '{1'b1, 12'h024, 32'h1234ABCD, 32'h0, 1'b0},   // R2
        '{1'b0, 12'h024, 32'h0, 32'hABCD, 1'b0},
        '{1'b1, 12'h028, 32'hFF, 32'h0, 1'b0},
        '{1'b0, 12'h028, 32'h0, 32'h3F, 1'b0},
        '{1'b1, 12'h02C, 32'h1FF, 32'h0, 1'b0},
        '{1'b0, 12'h02C, 32'h0, 32'hFF, 1'b0},
        '{1'b1, 12'h020, 32'h1AB, 32'h0, 1'b0},
        '{1'b0, 12'h020, 32'h0, 32'hAB, 1'b0},
        '{1'b1, 12'h018, 32'hFFFF, 32'h0, 1'b0},       // R7 write ignored
        '{1'b0, 12'h018, 32'h0, 32'h90, 1'b0},
        '{1'b0, 12'hFE0, 32'h0, 32'h11, 1'b0},         // R9
        '{1'b0, 12'hFFC, 32'h0, 32'hB1, 1'b0},
        '{1'b0, 12'hFE8, 32'h0, 32'h14, 1'b0},
        '{1'b0, 12'h004, 32'h0, 32'h0, 1'b1},          // R10
        '{1'b0, 12'h100, 32'h0, 32'h0, 1'b1},
        '{1'b1, 12'hFF0, 32'h0, 32'h0, 1'b1},
        '{1'b1, 12'h048, 32'h4, 32'h0, 1'b0},          // R11
        '{1'b0, 12'h048, 32'h0, 32'h4, 1'b0},
        '{1'b1, 12'h048, 32'h1, 32'h0, 1'b1},
        '{1'b0, 12'h048, 32'h0, 32'h1, 1'b0},
        '{1'b1, 12'h030, 32'hABCD1234, 32'h0, 1'b0},   // R2
        '{1'b0, 12'h030, 32'h0, 32'h1234, 1'b0},
        '{1'b1, 12'h034, 32'h3F, 32'h0, 1'b0},
        '{1'b0, 12'h034, 32'h0, 32'h3F, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = w; addr = a; wdata = d; rx_push = push_with;
        #1 pop_seen = rx_pop;
        @(negedge clk);
        got_rd = rdata; got_err = err; got_tx = tx_valid; got_txb = tx_byte;
        sel = 1'b0; wr = 1'b0; rx_push = 1'b0;
    endtask

    task automatic rd_expect(input logic [11:0] a, input logic [31:0] exp, input string req);
        bus(1'b0, a, 32'h0);
        check(got_rd == exp, req, got_rd, exp);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        push_with = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq == 1'b0, "R1 irq", 32'(irq), 0);
        check(err == 1'b0 && tx_valid == 1'b0, "R1 err/tx", {err, tx_valid}, 0);
        rd_expect(12'h03C, 32'h0, "R1 raw");

        for (int i = 0; i < NV; i++) begin
            bus(VEC[i].w, VEC[i].a, VEC[i].d);
            if (!VEC[i].w) check(got_rd == VEC[i].exp, $sformatf("R2 table[%0d] rdata", i), got_rd, VEC[i].exp);
            check(got_err == VEC[i].exp_err, $sformatf("R10 table[%0d] err", i), 32'(got_err), 32'(VEC[i].exp_err));
        end

        // R3 transmit strobe and raw bit
        bus(1'b1, 12'h000, 32'h1A5);
        check(got_tx == 1'b1 && got_txb == 8'hA5, "R3 strobe", {got_tx, got_txb}, 32'h1A5);
        @(negedge clk);
        check(tx_valid == 1'b0, "R3 single pulse", 32'(tx_valid), 0);
        rd_expect(12'h03C, 32'h20, "R3 raw tx bit");
        check(irq == 1'b0, "R6 masked off", 32'(irq), 0);

        // R6 mask and masked view
        bus(1'b1, 12'h038, 32'h30);
        check(irq == 1'b1, "R6 irq on mask", 32'(irq), 1);
        rd_expect(12'h040, 32'h20, "R6 masked");

        // R5 write-one-to-clear
        bus(1'b1, 12'h044, 32'h10);
        rd_expect(12'h03C, 32'h20, "R5 unnamed bit kept");
        bus(1'b1, 12'h044, 32'h20);
        check(irq == 1'b0, "R6 irq after clear", 32'(irq), 0);
        rd_expect(12'h03C, 32'h0, "R5 cleared");

        // R4 receive push
        @(negedge clk); rx_push = 1'b1;
        @(negedge clk); rx_push = 1'b0;
        check(irq == 1'b1, "R6 irq on rx", 32'(irq), 1);
        rd_expect(12'h03C, 32'h10, "R4 rx set");

        // R8 data read pops, R4 last entry clears
        rx_count = CW'(1); rx_data = 12'h4AB;
        bus(1'b0, 12'h000, 32'h0);
        check(pop_seen == 1'b1, "R8 pop", 32'(pop_seen), 1);
        check(got_rd == 32'h4AB, "R8 data", got_rd, 32'h4AB);
        check(irq == 1'b0, "R4 irq drop", 32'(irq), 0);
        rd_expect(12'h03C, 32'h0, "R4 rx cleared");

        // R4 push wins over drain in same cycle
        push_with = 1'b1;
        bus(1'b0, 12'h000, 32'h0);
        push_with = 1'b0;
        rd_expect(12'h03C, 32'h10, "R4 push wins");
        bus(1'b1, 12'h044, 32'h10);

        // R8 empty read does not pop
        rx_count = '0;
        bus(1'b0, 12'h000, 32'h0);
        check(pop_seen == 1'b0, "R8 no pop when empty", 32'(pop_seen), 0);
        rd_expect(12'h03C, 32'h0, "R4 no change on empty read");

        // R7 flags at full and partial fill
        rx_count = CW'(DEPTH);
        rd_expect(12'h018, 32'hC0, "R7 full");
        rx_count = CW'(5);
        rd_expect(12'h018, 32'h80, "R7 partial");

        finish_run();
    end
endmodule